// File: doc/BRIEF.md
# Threshold Alarm Flag Unit

This block watches two streams of measurement results, one from a temperature converter and one from a serial data input, and compares each accepted result against a programmable low and high threshold. Only the most significant byte of a result takes part in the comparison, so the outcome is the same whether the result was taken at 8-bit or 16-bit resolution. A comparison that reaches its threshold sets a sticky flag, as long as a mission is running and the enable bit for that comparison is set.

The four flags are visible on a status port, and a registered alarm output is high while any flag is set. The flags stay set until the clear input is pulsed or a new mission begins. Temperature thresholds use the logger's byte encoding (value = 2 x degrees C + 82, 0.5 degree steps; 00h means too cold, FFh means too hot). Serial data thresholds are plain unsigned bytes. The block that produces the measurements and the register bus that loads the thresholds are outside this unit.

Each result stream uses valid/ready. The unit never applies back-pressure: ready is always high, so every cycle with valid high transfers one result and triggers one comparison.

Top module: `thr_alarm_unit`

## Requirements
- R1: Temperature-low flag (status bit 0) is set at the clock edge after an accepted temperature result whose bits [15:8] are less than or equal to the low temperature threshold.
- R2: Temperature-high flag (status bit 1) is set at the clock edge after an accepted temperature result whose bits [15:8] are greater than or equal to the high temperature threshold.
- R3: Data-low flag (status bit 2) and data-high flag (status bit 3) are set under the same inclusive unsigned rules, applied to bits [15:8] of an accepted serial data result and the two data thresholds.
- R4: Bits [7:0] of either result have no effect on any flag.
- R5: Each of the four comparisons has its own enable input. While an enable is 0, its flag is never set.
- R6: Flags are set only while the mission input is high. Results accepted while it is low set no flag.
- R7: Flags are sticky. A set flag stays set through later results that do not qualify, through idle cycles, and through the end of a mission.
- R8: All four flags are cleared at the clock edge after a cycle with the clear input high, or with the mission input high when it was low in the previous cycle. A clear in the same cycle as a qualifying result wins, and the flags are 0 afterwards.
- R9: The alarm output equals the OR of the four flags, delayed by one cycle.
- R10: A comparison happens only in a cycle where the result's valid input is high. Both ready outputs are always high.
- R11: After reset, all flags and the alarm output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mission_i | input | 1 | High while a mission is running |
| clear_i | input | 1 | Clears all flags |
| thr_tlo_i | input | 8 | Temperature low threshold |
| thr_thi_i | input | 8 | Temperature high threshold |
| thr_dlo_i | input | 8 | Data low threshold |
| thr_dhi_i | input | 8 | Data high threshold |
| en_tlo_i | input | 1 | Enables the temperature-low comparison |
| en_thi_i | input | 1 | Enables the temperature-high comparison |
| en_dlo_i | input | 1 | Enables the data-low comparison |
| en_dhi_i | input | 1 | Enables the data-high comparison |
| temp_valid_i | input | 1 | Temperature result valid |
| temp_data_i | input | 16 | Temperature result |
| temp_ready_o | output | 1 | Temperature result ready (always 1) |
| dat_valid_i | input | 1 | Serial data result valid |
| dat_data_i | input | 16 | Serial data result |
| dat_ready_o | output | 1 | Serial data result ready (always 1) |
| flags_o | output | 4 | {data-high, data-low, temp-high, temp-low} |
| alarm_o | output | 1 | High while any flag was set in the previous cycle |

## Verification
The properties assume that the threshold and enable inputs are held steady by the register bus and change only between cycles. They do not assume any relation between valid strobes, the mission input and the clear input, so any combination in any cycle is legal. The stimulus keeps the clear pulses and mission changes rare, so that flags have time to build up and stay set. It also steers the result high bytes to land on, just above, and just below each threshold, and it fills the low bytes with random values so that they could mislead a comparison if they were used.

// File: rtl/thr_alarm_pkg.sv
package thr_alarm_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_FLAGS = 2 * NUM_CH;

  typedef enum logic [1:0] {
    FLG_TLO = 2'd0,
    FLG_THI = 2'd1,
    FLG_DLO = 2'd2,
    FLG_DHI = 2'd3
  } flag_idx_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } hit_pair_t;
endpackage

// File: rtl/thr_chan_cmp.sv
module thr_chan_cmp
  import thr_alarm_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int CMP_W = 8
) (
  input  logic             valid_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             armed_i,
  input  logic [CMP_W-1:0] thr_lo_i,
  input  logic [CMP_W-1:0] thr_hi_i,
  input  logic             en_lo_i,
  input  logic             en_hi_i,
  output hit_pair_t        hit_o
);
  localparam int LSB_W = RES_W - CMP_W;

  logic [CMP_W-1:0] top_byte;
  assign top_byte = data_i[RES_W-1 -: CMP_W];

  generate
    if (LSB_W > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^data_i[LSB_W-1:0];
    end
  endgenerate

  logic qual;
  assign qual = valid_i & armed_i;

  always_comb begin
    hit_o.lo = qual & en_lo_i & (top_byte <= thr_lo_i);
    hit_o.hi = qual & en_hi_i & (top_byte >= thr_hi_i);
  end
endmodule

// File: rtl/thr_flag_bank.sv
module thr_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)      flags_o[i] <= 1'b0;
        else if (clr_i)  flags_o[i] <= 1'b0;
        else if (set_i[i]) flags_o[i] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/thr_alarm_or.sv
module thr_alarm_or #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  output logic         alarm_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) alarm_o <= 1'b0;
    else        alarm_o <= |flags_i;
  end
endmodule

// File: rtl/thr_alarm_unit.sv
module thr_alarm_unit
  import thr_alarm_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mission_i,
  input  logic             clear_i,
  input  logic [CMP_W-1:0] thr_tlo_i,
  input  logic [CMP_W-1:0] thr_thi_i,
  input  logic [CMP_W-1:0] thr_dlo_i,
  input  logic [CMP_W-1:0] thr_dhi_i,
  input  logic             en_tlo_i,
  input  logic             en_thi_i,
  input  logic             en_dlo_i,
  input  logic             en_dhi_i,
  input  logic             temp_valid_i,
  input  logic [RES_W-1:0] temp_data_i,
  output logic             temp_ready_o,
  input  logic             dat_valid_i,
  input  logic [RES_W-1:0] dat_data_i,
  output logic             dat_ready_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic             alarm_o
);
  // The unit accepts every result: no back-pressure.
  assign temp_ready_o = 1'b1;
  assign dat_ready_o  = 1'b1;

  // Mission edge detection
  logic mission_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mission_q <= 1'b0;
    else        mission_q <= mission_i;
  end

  logic clr;
  assign clr = clear_i | (mission_i & ~mission_q);

  // Per-channel input arrays
  logic             ch_valid [NUM_CH];
  logic [RES_W-1:0] ch_data  [NUM_CH];
  logic [CMP_W-1:0] ch_tlo   [NUM_CH];
  logic [CMP_W-1:0] ch_thi   [NUM_CH];
  logic             ch_enlo  [NUM_CH];
  logic             ch_enhi  [NUM_CH];
  hit_pair_t        ch_hit   [NUM_CH];

  always_comb begin
    ch_valid[0] = temp_valid_i; ch_data[0] = temp_data_i;
    ch_tlo[0]   = thr_tlo_i;    ch_thi[0]  = thr_thi_i;
    ch_enlo[0]  = en_tlo_i;     ch_enhi[0] = en_thi_i;
    ch_valid[1] = dat_valid_i;  ch_data[1] = dat_data_i;
    ch_tlo[1]   = thr_dlo_i;    ch_thi[1]  = thr_dhi_i;
    ch_enlo[1]  = en_dlo_i;     ch_enhi[1] = en_dhi_i;
  end

  logic [NUM_FLAGS-1:0] set_vec;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      thr_chan_cmp #(.RES_W(RES_W), .CMP_W(CMP_W)) u_cmp (
        .valid_i  (ch_valid[c]),
        .data_i   (ch_data[c]),
        .armed_i  (mission_i),
        .thr_lo_i (ch_tlo[c]),
        .thr_hi_i (ch_thi[c]),
        .en_lo_i  (ch_enlo[c]),
        .en_hi_i  (ch_enhi[c]),
        .hit_o    (ch_hit[c])
      );
      assign set_vec[2*c]   = ch_hit[c].lo;
      assign set_vec[2*c+1] = ch_hit[c].hi;
    end
  endgenerate

  thr_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .set_i   (set_vec),
    .flags_o (flags_o)
  );

  thr_alarm_or #(.N(NUM_FLAGS)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags_o),
    .alarm_o (alarm_o)
  );
endmodule

// File: rtl/thr_alarm_chk.sv
module thr_alarm_chk #(
  parameter int RES_W = 16,
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mission_i,
  input logic             clear_i,
  input logic [CMP_W-1:0] thr_tlo_i,
  input logic [CMP_W-1:0] thr_thi_i,
  input logic [CMP_W-1:0] thr_dlo_i,
  input logic [CMP_W-1:0] thr_dhi_i,
  input logic             en_tlo_i,
  input logic             en_thi_i,
  input logic             en_dlo_i,
  input logic             en_dhi_i,
  input logic             temp_valid_i,
  input logic [RES_W-1:0] temp_data_i,
  input logic             temp_ready_o,
  input logic             dat_valid_i,
  input logic [RES_W-1:0] dat_data_i,
  input logic             dat_ready_o,
  input logic [3:0]       flags_o,
  input logic             alarm_o
);
  logic mq;
  logic [3:0] flags_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mq <= 1'b0;
      flags_prev <= '0;
    end else begin
      mq <= mission_i;
      flags_prev <= flags_o;
    end
  end

  logic wipe;
  assign wipe = clear_i | (mission_i & ~mq);

  logic [CMP_W-1:0] t_top, d_top;
  assign t_top = temp_data_i[RES_W-1 -: CMP_W];
  assign d_top = dat_data_i[RES_W-1 -: CMP_W];

  assert_tlo_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid_i && mission_i && en_tlo_i && !wipe && t_top <= thr_tlo_i) |=> flags_o[0]);

  assert_thi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid_i && mission_i && en_thi_i && !wipe && t_top >= thr_thi_i) |=> flags_o[1]);

  assert_data_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid_i && mission_i && !wipe &&
     ((en_dlo_i && d_top <= thr_dlo_i) || (en_dhi_i && d_top >= thr_dhi_i)))
    |=> (flags_o[2] || flags_o[3]));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_o[0] && !en_tlo_i) |=> !flags_o[0]);

  assert_idle_mission_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mission_i && flags_o == 4'b0) |=> flags_o == 4'b0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe) |=> ((flags_o & flags_prev) == flags_prev));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> flags_o == 4'b0);

  assert_alarm_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o == (|flags_prev));

  assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_valid_i && !dat_valid_i && flags_o == 4'b0) |=> flags_o == 4'b0);

  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    temp_ready_o && dat_ready_o);
endmodule

bind thr_alarm_unit thr_alarm_chk #(.RES_W(RES_W), .CMP_W(CMP_W)) u_chk (.*);

// File: tb/thr_alarm_unit_tb.sv
module thr_alarm_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, mission, clear;
  logic [7:0]  thr_tlo, thr_thi, thr_dlo, thr_dhi;
  logic        en_tlo, en_thi, en_dlo, en_dhi;
  logic        t_valid, d_valid;
  logic [15:0] t_data, d_data;
  logic        t_ready, d_ready;
  logic [3:0]  flags;
  logic        alarm;

  int checks = 0;
  int failures = 0;

  thr_alarm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mission_i(mission), .clear_i(clear),
    .thr_tlo_i(thr_tlo), .thr_thi_i(thr_thi), .thr_dlo_i(thr_dlo), .thr_dhi_i(thr_dhi),
    .en_tlo_i(en_tlo), .en_thi_i(en_thi), .en_dlo_i(en_dlo), .en_dhi_i(en_dhi),
    .temp_valid_i(t_valid), .temp_data_i(t_data), .temp_ready_o(t_ready),
    .dat_valid_i(d_valid), .dat_data_i(d_data), .dat_ready_o(d_ready),
    .flags_o(flags), .alarm_o(alarm)
  );

  // Reference model state
  logic [3:0] m_flags;
  logic       m_mq;

  function automatic logic [3:0] next_flags(logic [3:0] cur, logic mq);
    logic [3:0] s;
    if (clear || (mission && !mq)) return 4'b0;
    s = 4'b0;
    if (mission) begin
      s[0] = t_valid && en_tlo && (t_data[15:8] <= thr_tlo);
      s[1] = t_valid && en_thi && (t_data[15:8] >= thr_thi);
      s[2] = d_valid && en_dlo && (d_data[15:8] <= thr_dlo);
      s[3] = d_valid && en_dhi && (d_data[15:8] >= thr_dhi);
    end
    return cur | s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply current inputs over one clock edge, then check against the model.
  task automatic step(string tag);
    logic [3:0] nf;
    logic       ea;
    nf = next_flags(m_flags, m_mq);
    ea = |m_flags;
    @(posedge clk);
    @(negedge clk);
    m_flags = nf;
    m_mq    = mission;
    chk({tag, " flags"}, {28'b0, flags}, {28'b0, m_flags});
    chk("R9 alarm", {31'b0, alarm}, {31'b0, ea});
    chk("R10 ready", {30'b0, t_ready, d_ready}, 32'h3);
  endtask

  task automatic idle_inputs();
    t_valid = 0; d_valid = 0; clear = 0;
    t_data = 16'h0; d_data = 16'h0;
  endtask

  function automatic logic [7:0] near(logic [7:0] thr);
    int unsigned r;
    r = $urandom_range(0, 5);
    case (r)
      0: return thr;
      1: return thr + 8'd1;
      2: return thr - 8'd1;
      3: return 8'h00;
      4: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #900000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; mission = 0; idle_inputs();
    thr_tlo = 8'h3E; thr_thi = 8'h85; thr_dlo = 8'h10; thr_dhi = 8'hF0;
    en_tlo = 1; en_thi = 1; en_dlo = 1; en_dhi = 1;
    m_flags = 4'b0; m_mq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset flags", {28'b0, flags}, 32'h0);
    chk("R11 reset alarm", {31'b0, alarm}, 32'h0);

    // Mission start
    mission = 1; step("R8 start");
    // R1: equal to low threshold, low byte FF (R4)
    t_valid = 1; t_data = 16'h3EFF; step("R1 equal low");
    t_valid = 0; step("R7 hold");
    chk("R1 tlo set", {28'b0, flags}, 32'h1);
    chk("R9 alarm up", {31'b0, alarm}, 32'h1);
    clear = 1; step("R8 clear"); clear = 0;
    chk("R8 cleared", {28'b0, flags}, 32'h0);
    // R1 strict boundary: one above low threshold
    t_valid = 1; t_data = 16'h3F00; step("R1 above low");
    chk("R1 no flag", {28'b0, flags}, 32'h0);
    // R2 and R4: 84FF below, 8500 at
    t_data = 16'h84FF; step("R4 low byte ignored");
    chk("R4 no flag", {28'b0, flags}, 32'h0);
    t_data = 16'h8500; step("R2 equal high");
    chk("R2 thi set", {28'b0, flags}, 32'h2);
    t_valid = 0; clear = 1; step("R8 clear"); clear = 0;
    // R3: data at low threshold and at high threshold, same cycle as hot temp FF
    d_valid = 1; d_data = 16'h1000; t_valid = 1; t_data = 16'hFF00; step("R3 data low");
    chk("R3 dlo+thi", {28'b0, flags}, 32'h6);
    t_valid = 0; d_data = 16'hF0AB; step("R3 data high");
    chk("R3 dhi", {28'b0, flags}, 32'hE);
    d_data = 16'h1100; step("R3 data mid");
    d_valid = 0; clear = 1; step("R8 clear"); clear = 0;
    // R5: enables off
    en_tlo = 0; en_thi = 0; en_dlo = 0; en_dhi = 0;
    t_valid = 1; t_data = 16'h0000; d_valid = 1; d_data = 16'hFFFF; step("R5 disabled");
    t_data = 16'hFFFF; d_data = 16'h0000; step("R5 disabled");
    chk("R5 none", {28'b0, flags}, 32'h0);
    en_tlo = 1; en_thi = 1; en_dlo = 1; en_dhi = 1;
    // R6: mission off
    mission = 0; t_data = 16'h0000; d_data = 16'hFFFF; step("R6 no mission");
    chk("R6 none", {28'b0, flags}, 32'h0);
    // R8: restart mission clears, and a qualifying result in that cycle is dropped
    mission = 1; step("R8 start wins");
    chk("R8 start dropped", {28'b0, flags}, 32'h0);
    step("R1 set");
    // R7: sticky over idle and mission end
    idle_inputs(); repeat (4) step("R7 idle");
    mission = 0; step("R7 mission end");
    chk("R7 sticky", {28'b0, flags}, 32'h9);
    // R8: clear wins over a simultaneous qualifying result
    mission = 1; step("R8 restart");
    clear = 1; t_valid = 1; t_data = 16'h0000; step("R8 clear wins");
    chk("R8 clear wins", {28'b0, flags}, 32'h0);
    // R10: no valid, matching data
    idle_inputs(); t_data = 16'h0000; d_data = 16'hFFFF; step("R10 no strobe");
    chk("R10 none", {28'b0, flags}, 32'h0);

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      if ((i % 400) == 0) begin
        thr_tlo = 8'($urandom); thr_thi = 8'($urandom);
        thr_dlo = 8'($urandom); thr_dhi = 8'($urandom);
        {en_tlo, en_thi, en_dlo, en_dhi} = 4'($urandom);
      end
      if ($urandom_range(0, 63) == 0) mission = ~mission;
      clear   = ($urandom_range(0, 47) == 0);
      t_valid = $urandom_range(0, 1) == 1;
      d_valid = $urandom_range(0, 1) == 1;
      t_data  = {(($urandom_range(0, 1) == 1) ? near(thr_tlo) : near(thr_thi)), 8'($urandom)};
      d_data  = {(($urandom_range(0, 1) == 1) ? near(thr_dlo) : near(thr_dhi)), 8'($urandom)};
      step("R1 R2 R3 R5 R6 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule